// File: doc/BRIEF.md
# Serial Register Access Controller

This block is the slave end of a four-wire serial port that gives a host access to the register bank of a data converter. The wires are serial clock, data in, data out and an active-low chip select. The block runs on the chip's own system clock. It oversamples the serial lines through synchronizer stages and acts on the detected clock edges. Every transaction opens with an 8-bit command byte. The command byte names a target register and the direction of the transfer, and it also sets the standby and channel fields. The block then moves exactly as many bits as that register holds, either into the register or out of it. After that it waits for the next command byte.

The configuration registers live inside the block and drive parallel outputs toward the converter core. The core supplies the conversion word and the data-ready flag as inputs. A run of ones on the data line acts as an escape that resynchronizes the port and restores every register. Deasserting chip select abandons a partial transfer. The serial wires carry no flow control: the host owns the serial clock, so there is no valid/ready handshake and no back-pressure. Each bit is taken or given on the host's edge.

Top module: `ser_regif`

## Requirements
- R1: After reset the outputs hold these values: setup 0x01, clock config 0x05, test 0x00, offset 0x800000, gain 0x400000, standby 0, channel 0, and sdo low.
- R2: Serial data is MSB first and is sampled on the rising sclk edge. A command byte is, from MSB down: a start bit that must be 0, select[2:0], direction (1 = read, 0 = write), standby, channel[1:0].
- R3: While the bit at the first position of a command byte arrives as 1, it is discarded and the position does not advance. The first 0 starts the byte, and seven more bits complete it.
- R4: Every command byte loads the standby and channel outputs from its bits. A command with select 000 and direction 0 needs no further transfer, and the next byte is again a command.
- R5: Transfer lengths by select code are: 001 setup 8 bits, 010 clock config 8, 011 data 16, 100 test 8, 110 offset 24, 111 gain 24. A written register changes only when its final bit arrives, and no other register changes.
- R6: On a read, the register's MSB is on sdo before the next rising sclk edge. Each later bit appears after a falling edge. sdo is low whenever no read is in progress.
- R7: A read of the command register (select 000, direction 1) returns data_ready as its MSB, followed by the low seven bits of that same command byte.
- R8: A read of the data register returns data_word. A write to it consumes 16 bits and changes nothing.
- R9: Select 101 moves no data, and the next byte is a command.
- R10: After a read or write completes, the next byte is taken as a command, so transactions can follow back to back.
- R11: Raising cs_n aborts any partial command or transfer and leaves the registers as they were. The next transaction starts with a command byte.
- R12: When 32 consecutive rising sclk edges with sdi high are seen while selected, the port returns to waiting for a command and all registers return to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| cs_n | input | 1 | Active-low select |
| sdo | output | 1 | Serial data to host |
| data_word | input | 16 | Conversion result from core |
| data_ready | input | 1 | Conversion-ready flag from core |
| standby | output | 1 | Standby field of last command |
| channel | output | 2 | Channel field of last command |
| setup_q | output | 8 | Setup register |
| clkcfg_q | output | 8 | Clock config register |
| test_q | output | 8 | Test register |
| offset_q | output | 24 | Offset register |
| gain_q | output | 24 | Gain register |

## Verification
The register path is exercised with every select code, so each of the three transfer lengths shows up as correct framing of the transaction that follows it. Writes are read back with distinct patterns that tell a shifted or truncated word apart from a correct one. Command read-back is tried with data_ready both high and low, and with different standby and channel fields, so that a stale or swapped bit is caught. Separate patterns cover leading ones before a command, an aborted gain write, and a long run of ones. Each of these is followed by a normal transaction, which shows that the port came back in step.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL  = 3'b000,
    SEL_SETUP = 3'b001,
    SEL_CLK   = 3'b010,
    SEL_DATA  = 3'b011,
    SEL_TEST  = 3'b100,
    SEL_NOP   = 3'b101,
    SEL_OFS   = 3'b110,
    SEL_GAIN  = 3'b111
  } sel_e;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_e;

  // number of serial bits a select code moves
  function automatic int unsigned sel_bits(input sel_e s, input int unsigned dw,
                                           input int unsigned cw);
    case (s)
      SEL_DATA:          return dw;
      SEL_OFS, SEL_GAIN: return cw;
      default:           return 8;
    endcase
  endfunction
endpackage

// File: rtl/ser_in_sync.sv
`timescale 1ns/1ps
module ser_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic cs_n_i,
  output logic rise,
  output logic fall,
  output logic sdi_s,
  output logic cs_act
);
  logic [2:0] raw;
  logic [2:0] rst_val;
  logic [2:0] synced;
  logic       sclk_last;

  assign raw     = {cs_n_i, sdi_i, sclk_i};
  assign rst_val = 3'b100;

  // one synchronizer chain per serial line
  for (genvar g = 0; g < 3; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{rst_val[g]}};
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign synced[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_last <= 1'b0;
    else        sclk_last <= synced[0];
  end

  assign rise   = synced[0] & ~sclk_last;
  assign fall   = ~synced[0] & sclk_last;
  assign sdi_s  = synced[1];
  assign cs_act = ~synced[2];
endmodule

// File: rtl/ser_ones_watch.sv
`timescale 1ns/1ps
module ser_ones_watch #(
  parameter int RUN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic sdi,
  input  logic cs_act,
  output logic resync
);
  localparam int CW = $clog2(RUN);
  logic [CW-1:0] run_cnt;

  assign resync = cs_act & rise & sdi & (run_cnt == CW'(RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_cnt <= '0;
    else if (!cs_act || resync) run_cnt <= '0;
    else if (rise)             run_cnt <= sdi ? run_cnt + 1'b1 : '0;
  end
endmodule

// File: rtl/ser_frame_fsm.sv
`timescale 1ns/1ps
module ser_frame_fsm import ser_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int CAL_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic             sdi,
  input  logic             cs_act,
  input  logic             resync,
  input  logic [CAL_W-1:0] rd_val,
  output sel_e             rd_sel,
  output logic             cmd_we,
  output logic [6:0]       cmd_bits,
  output logic             wr_en,
  output sel_e             wr_sel,
  output logic [CAL_W-1:0] wr_val,
  output logic             sdo
);
  localparam int CNT_W = $clog2(CAL_W);

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   last_idx;
  logic [CAL_W-2:0]   sh_in;
  logic [CAL_W-1:0]   sh_out;
  sel_e               cur_sel;

  logic               step;
  logic [7:0]         byte_nx;
  logic               byte_done;
  sel_e               new_sel;
  logic               new_rw;
  int unsigned        new_len;
  logic [CAL_W-1:0]   rd_aligned;

  assign step      = rise & cs_act & ~resync;
  assign byte_nx   = {sh_in[6:0], sdi};
  assign byte_done = step && (phase == PH_CMD) && (cnt == CNT_W'(7));
  assign new_sel   = sel_e'(byte_nx[6:4]);
  assign new_rw    = byte_nx[3];
  assign new_len   = sel_bits(new_sel, DATA_W, CAL_W);
  assign rd_aligned = rd_val << (CAL_W - new_len);

  assign rd_sel   = new_sel;
  assign cmd_we   = byte_done;
  assign cmd_bits = byte_nx[6:0];
  assign wr_sel   = cur_sel;
  assign wr_val   = {sh_in, sdi};
  assign wr_en    = step && (phase == PH_WR) && (cnt == last_idx);
  assign sdo      = (phase == PH_RD) & sh_out[CAL_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      cnt      <= '0;
      last_idx <= CNT_W'(7);
      sh_in    <= '0;
      sh_out   <= '0;
      cur_sel  <= SEL_CTRL;
    end else if (!cs_act || resync) begin
      phase <= PH_CMD;
      cnt   <= '0;
    end else if (rise) begin
      case (phase)
        PH_CMD: begin
          if (!(cnt == '0 && sdi)) begin
            sh_in <= {sh_in[CAL_W-3:0], sdi};
            if (cnt == CNT_W'(7)) begin
              cnt      <= '0;
              cur_sel  <= new_sel;
              last_idx <= CNT_W'(new_len - 1);
              if (new_sel == SEL_NOP || (new_sel == SEL_CTRL && !new_rw)) begin
                phase <= PH_CMD;
              end else if (new_rw) begin
                phase  <= PH_RD;
                sh_out <= rd_aligned;
              end else begin
                phase <= PH_WR;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_WR: begin
          sh_in <= {sh_in[CAL_W-3:0], sdi};
          if (cnt == last_idx) begin
            phase <= PH_CMD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RD: begin
          if (cnt == last_idx) begin
            phase <= PH_CMD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_CMD;
          cnt   <= '0;
        end
      endcase
    end else if (fall && phase == PH_RD && cnt != '0) begin
      sh_out <= sh_out << 1;
    end
  end
endmodule

// File: rtl/ser_reg_bank.sv
`timescale 1ns/1ps
module ser_reg_bank import ser_pkg::*; #(
  parameter int               DATA_W    = 16,
  parameter int               CAL_W     = 24,
  parameter logic [7:0]       SETUP_RST = 8'h01,
  parameter logic [7:0]       CLK_RST   = 8'h05,
  parameter logic [7:0]       TEST_RST  = 8'h00,
  parameter logic [CAL_W-1:0] OFS_RST   = 24'h800000,
  parameter logic [CAL_W-1:0] GAIN_RST  = 24'h400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resync,
  input  logic              cmd_we,
  input  logic [6:0]        cmd_bits,
  input  logic              wr_en,
  input  sel_e              wr_sel,
  input  logic [CAL_W-1:0]  wr_val,
  input  sel_e              rd_sel,
  input  logic [DATA_W-1:0] data_word,
  input  logic              data_ready,
  output logic [CAL_W-1:0]  rd_val,
  output logic              standby,
  output logic [1:0]        channel,
  output logic [7:0]        setup_q,
  output logic [7:0]        clkcfg_q,
  output logic [7:0]        test_q,
  output logic [CAL_W-1:0]  offset_q,
  output logic [CAL_W-1:0]  gain_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      standby  <= 1'b0;
      channel  <= 2'b00;
      setup_q  <= SETUP_RST;
      clkcfg_q <= CLK_RST;
      test_q   <= TEST_RST;
      offset_q <= OFS_RST;
      gain_q   <= GAIN_RST;
    end else if (resync) begin
      standby  <= 1'b0;
      channel  <= 2'b00;
      setup_q  <= SETUP_RST;
      clkcfg_q <= CLK_RST;
      test_q   <= TEST_RST;
      offset_q <= OFS_RST;
      gain_q   <= GAIN_RST;
    end else begin
      if (cmd_we) begin
        standby <= cmd_bits[2];
        channel <= cmd_bits[1:0];
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_SETUP: setup_q  <= wr_val[7:0];
          SEL_CLK:   clkcfg_q <= wr_val[7:0];
          SEL_TEST:  test_q   <= wr_val[7:0];
          SEL_OFS:   offset_q <= wr_val;
          SEL_GAIN:  gain_q   <= wr_val;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_CTRL:  rd_val = CAL_W'({data_ready, cmd_bits});
      SEL_SETUP: rd_val = CAL_W'(setup_q);
      SEL_CLK:   rd_val = CAL_W'(clkcfg_q);
      SEL_DATA:  rd_val = CAL_W'(data_word);
      SEL_TEST:  rd_val = CAL_W'(test_q);
      SEL_OFS:   rd_val = offset_q;
      SEL_GAIN:  rd_val = gain_q;
      default:   rd_val = '0;
    endcase
  end
endmodule

// File: rtl/ser_regif.sv
`timescale 1ns/1ps
module ser_regif import ser_pkg::*; #(
  parameter int               DATA_W      = 16,
  parameter int               CAL_W       = 24,
  parameter int               SYNC_STAGES = 2,
  parameter int               RESYNC_ONES = 32,
  parameter logic [7:0]       SETUP_RST   = 8'h01,
  parameter logic [7:0]       CLK_RST     = 8'h05,
  parameter logic [7:0]       TEST_RST    = 8'h00,
  parameter logic [CAL_W-1:0] OFS_RST     = 24'h800000,
  parameter logic [CAL_W-1:0] GAIN_RST    = 24'h400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  output logic              sdo,
  input  logic [DATA_W-1:0] data_word,
  input  logic              data_ready,
  output logic              standby,
  output logic [1:0]        channel,
  output logic [7:0]        setup_q,
  output logic [7:0]        clkcfg_q,
  output logic [7:0]        test_q,
  output logic [CAL_W-1:0]  offset_q,
  output logic [CAL_W-1:0]  gain_q
);
  logic             rise, fall, sdi_s, cs_act, resync;
  logic             cmd_we, wr_en;
  logic [6:0]       cmd_bits;
  sel_e             rd_sel, wr_sel;
  logic [CAL_W-1:0] rd_val, wr_val;

  ser_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .cs_n_i(cs_n),
    .rise(rise), .fall(fall), .sdi_s(sdi_s), .cs_act(cs_act)
  );

  ser_ones_watch #(.RUN(RESYNC_ONES)) u_watch (
    .clk(clk), .rst_n(rst_n), .rise(rise), .sdi(sdi_s), .cs_act(cs_act),
    .resync(resync)
  );

  ser_frame_fsm #(.DATA_W(DATA_W), .CAL_W(CAL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .sdi(sdi_s),
    .cs_act(cs_act), .resync(resync), .rd_val(rd_val), .rd_sel(rd_sel),
    .cmd_we(cmd_we), .cmd_bits(cmd_bits), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_val(wr_val), .sdo(sdo)
  );

  ser_reg_bank #(
    .DATA_W(DATA_W), .CAL_W(CAL_W), .SETUP_RST(SETUP_RST), .CLK_RST(CLK_RST),
    .TEST_RST(TEST_RST), .OFS_RST(OFS_RST), .GAIN_RST(GAIN_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .resync(resync), .cmd_we(cmd_we),
    .cmd_bits(cmd_bits), .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val),
    .rd_sel(rd_sel), .data_word(data_word), .data_ready(data_ready),
    .rd_val(rd_val), .standby(standby), .channel(channel), .setup_q(setup_q),
    .clkcfg_q(clkcfg_q), .test_q(test_q), .offset_q(offset_q), .gain_q(gain_q)
  );
endmodule

// File: rtl/ser_regif_chk.sv
`timescale 1ns/1ps
module ser_regif_chk #(
  parameter int               CAL_W     = 24,
  parameter logic [7:0]       SETUP_RST = 8'h01,
  parameter logic [CAL_W-1:0] GAIN_RST  = 24'h400000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic             sdi_s,
  input logic             cs_act,
  input logic             resync,
  input logic             cmd_we,
  input logic             wr_en,
  input logic             sdo,
  input logic             standby,
  input logic [1:0]       channel,
  input logic [7:0]       setup_q,
  input logic [CAL_W-1:0] offset_q,
  input logic [CAL_W-1:0] gain_q
);
  // R5
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, cmd_we}));

  // R5
  cal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !resync) |=> ($stable(gain_q) && $stable(offset_q)));

  // R4
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_we && !resync) |=> ($stable(standby) && $stable(channel)));

  // R11
  write_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cs_act);

  // R11
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo);

  // R12
  resync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> (rise && sdi_s && cs_act));

  // R12
  resync_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (setup_q == SETUP_RST && gain_q == GAIN_RST && !standby));
endmodule

bind ser_regif ser_regif_chk #(
  .CAL_W(CAL_W), .SETUP_RST(SETUP_RST), .GAIN_RST(GAIN_RST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .sdi_s(sdi_s), .cs_act(cs_act),
  .resync(resync), .cmd_we(cmd_we), .wr_en(wr_en), .sdo(sdo),
  .standby(standby), .channel(channel), .setup_q(setup_q),
  .offset_q(offset_q), .gain_q(gain_q)
);

// File: tb/tb_ser_regif.sv
`timescale 1ns/1ps
module tb_ser_regif;
  logic        clk = 1'b0;
  logic        rst_n, sclk, sdi, cs_n, data_ready;
  logic [15:0] data_word;
  logic        sdo, standby;
  logic [1:0]  channel;
  logic [7:0]  setup_q, clkcfg_q, test_q;
  logic [23:0] offset_q, gain_q;

  int          n_chk  = 0;
  int          n_fail = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];
  logic [23:0] got;
  event        rd_done;

  always #2 clk = ~clk;

  ser_regif dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n), .sdo(sdo),
    .data_word(data_word), .data_ready(data_ready), .standby(standby),
    .channel(channel), .setup_q(setup_q), .clkcfg_q(clkcfg_q), .test_q(test_q),
    .offset_q(offset_q), .gain_q(gain_q)
  );

  task automatic check(input bit ok, input string tag, input logic [23:0] act,
                       input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    #32 sclk = 1'b1;
    #32 sclk = 1'b0;
  endtask

  task automatic send_word(input logic [23:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  // driver: queues the expected word, then clocks the read out
  task automatic read_word(input logic [7:0] cmd, input int n, input string tag,
                           input logic [23:0] exp);
    send_word({16'h0, cmd}, 8);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    got = '0;
    sdi = 1'b0;
    for (int i = 0; i < n; i++) begin
      #32 got = {got[22:0], sdo};
      sclk = 1'b1;
      #32 sclk = 1'b0;
    end
    ->rd_done;
    #8;
  endtask

  // monitor: compares each finished read against the queue
  initial begin
    forever begin
      @(rd_done);
      check(got == exp_q[0], tag_q[0], got, exp_q[0]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic check_bank(input string tag, input logic [7:0] s, input logic [7:0] c,
                            input logic [7:0] t, input logic [23:0] o, input logic [23:0] g);
    check(setup_q == s, {tag, " setup"}, 24'(setup_q), 24'(s));
    check(clkcfg_q == c, {tag, " clkcfg"}, 24'(clkcfg_q), 24'(c));
    check(test_q == t, {tag, " test"}, 24'(test_q), 24'(t));
    check(offset_q == o, {tag, " offset"}, offset_q, o);
    check(gain_q == g, {tag, " gain"}, gain_q, g);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0; cs_n = 1'b1;
    data_ready = 1'b0; data_word = 16'h0;
    #40 rst_n = 1'b1;
    #20;
    // R1 reset state
    check_bank("R1", 8'h01, 8'h05, 8'h00, 24'h800000, 24'h400000);
    check(!standby && channel == 2'b00, "R1 ctrl", {21'h0, standby, channel}, 24'h0);
    check(sdo == 1'b0, "R1 sdo", 24'(sdo), 24'h0);
    cs_n = 1'b0;
    #20;

    // R2 R5 setup write, R6 R10 read back
    send_word(24'h10, 8); send_word(24'h5A, 8); #20;
    check(setup_q == 8'h5A, "R5 setup write", 24'(setup_q), 24'h5A);
    read_word(8'h18, 8, "R6 R10 setup read", 24'h5A);

    // R7 command read-back with ready high then low
    data_ready = 1'b1;
    read_word(8'h08, 8, "R7 ready high", 24'h88);
    data_ready = 1'b0;
    read_word(8'h0D, 8, "R7 ready low", 24'h0D);
    check(standby && channel == 2'b01, "R4 fields from read cmd",
          {21'h0, standby, channel}, 24'h5);

    // R4 command-only write then next byte is a command
    send_word(24'h03, 8); #20;
    check(!standby && channel == 2'b11, "R4 fields", {21'h0, standby, channel}, 24'h3);
    send_word(24'h20, 8); send_word(24'hC3, 8); #20;
    check(clkcfg_q == 8'hC3, "R4 R5 clkcfg", 24'(clkcfg_q), 24'hC3);
    read_word(8'h28, 8, "R5 clkcfg read", 24'hC3);

    // R3 leading ones are discarded
    send_word(24'h1F, 5); send_word(24'h40, 8); send_word(24'h9C, 8); #20;
    check(test_q == 8'h9C, "R3 test write", 24'(test_q), 24'h9C);
    read_word(8'h48, 8, "R3 test read", 24'h9C);

    // R5 24-bit registers
    send_word(24'h60, 8); send_word(24'h123456, 24); #20;
    read_word(8'h68, 24, "R5 offset read", 24'h123456);
    send_word(24'h70, 8); send_word(24'hABCDEF, 24); #20;
    read_word(8'h78, 24, "R5 gain read", 24'hABCDEF);

    // R8 data register
    data_word = 16'hBEEF;
    read_word(8'h38, 16, "R8 data read", 24'h00BEEF);
    send_word(24'h30, 8); send_word(24'h001234, 16); #20;
    check_bank("R8 data write ignored", 8'h5A, 8'hC3, 8'h9C, 24'h123456, 24'hABCDEF);
    read_word(8'h18, 8, "R8 R10 framing after data", 24'h5A);

    // R9 no-operation select
    send_word(24'h50, 8);
    read_word(8'h18, 8, "R9 nop then read", 24'h5A);
    check(sdo == 1'b0, "R6 sdo idle", 24'(sdo), 24'h0);

    // R11 abort mid gain write
    send_word(24'h70, 8); send_word(24'h3FF, 10);
    cs_n = 1'b1; #40;
    check(gain_q == 24'hABCDEF, "R11 gain kept", gain_q, 24'hABCDEF);
    cs_n = 1'b0; #40;
    read_word(8'h78, 24, "R11 read after abort", 24'hABCDEF);

    // R12 long run of ones
    send_word(24'hFFFFFF, 24); send_word(24'hFFFF, 16); #20;
    check_bank("R12 restore", 8'h01, 8'h05, 8'h00, 24'h800000, 24'h400000);
    check(!standby && channel == 2'b00, "R12 ctrl", {21'h0, standby, channel}, 24'h0);
    read_word(8'h18, 8, "R12 read after resync", 24'h01);

    #40;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule